// File: doc/BRIEF.md
# Pulse-Coded Level Isolation Link

This block carries a single logic level from a transmit half to a receive half over two one-bit pulse lines, an "up" line and a "down" line. The transmit half turns each input transition into a one-cycle pulse whose line gives the new level. While the input stays still, it repeats a pulse of the matching polarity at a fixed interval, so the far side keeps a correct DC level. The receive half is a bistable decoder: an up pulse makes the output high and a down pulse makes it low. A watchdog on the receive half forces the output high and raises a stale flag when pulses stop arriving.

The two halves share one clock but have separate active-low asynchronous resets, so either side can be held in reset without the other. The pulse lines are brought out as ports. The integrator connects the transmit outputs to the receive inputs, and any barrier or gating can sit between them. The data input is a plain level, sampled on every clock edge. It has no valid/ready handshake and no back-pressure: the transmit half can never refuse a transition, and a change is encoded on the edge that first samples it. The refresh interval and the watchdog timeout are parameters counted in clock cycles. The timeout must be larger than the refresh interval, and the refresh interval must be at least 2.

Top module: `isolink_top`

## Requirements
- R1: When the edge that samples `din_i` sees a new value, the transmit half drives a pulse in the following cycle. A rising input gives a pulse on `tx_up_o` and a falling input gives a pulse on `tx_dn_o`.
- R2: Every transmit pulse lasts exactly one clock cycle, and `tx_up_o` and `tx_dn_o` are never high in the same cycle.
- R3: While `din_i` holds still, a pulse whose polarity matches `din_i` (up when the input is 1, down when it is 0) is sent every REFRESH_CYC cycles. This interval timer restarts on every pulse, whether the pulse came from a transition or from a refresh.
- R4: On the first clock edge after `tx_rst_n` is released, the transmit half sends one pulse that matches the current `din_i` level. The refresh interval then counts from that pulse.
- R5: A receive cycle in which only `rx_up_i` is high makes `dout_o` 1 after that edge. A receive cycle in which only `rx_dn_i` is high makes `dout_o` 0 after that edge.
- R6: A cycle in which `rx_up_i` and `rx_dn_i` are both high is not a valid pulse. The decoded level holds, and the watchdog is not restarted.
- R7: If the receive half sees no valid pulse for TIMEOUT_CYC consecutive cycles, `stale_o` rises and `dout_o` is forced to 1. Both stay that way until a valid pulse arrives.
- R8: A valid pulse that arrives while the link is stale clears `stale_o` and applies its own level to `dout_o` after that same edge.
- R9: While reset is held, `tx_up_o` and `tx_dn_o` are 0. `dout_o` is 1 and `stale_o` is 1 from receive reset until the first valid pulse.
- R10: With the pulse lines connected directly and the transmit half out of reset, `stale_o` never asserts once the first pulse has been received, because TIMEOUT_CYC exceeds REFRESH_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| tx_rst_n | input | 1 | Transmit half reset, active low, asynchronous |
| rx_rst_n | input | 1 | Receive half reset, active low, asynchronous |
| din_i | input | 1 | Level to carry, sampled on every edge |
| tx_up_o | output | 1 | Transmit pulse meaning "level is 1" |
| tx_dn_o | output | 1 | Transmit pulse meaning "level is 0" |
| rx_up_i | input | 1 | Receive side of the up pulse line |
| rx_dn_i | input | 1 | Receive side of the down pulse line |
| dout_o | output | 1 | Decoded level, forced to 1 while stale |
| stale_o | output | 1 | High while the watchdog forces the output |

## Verification
Two things can coincide on the receive half. A valid pulse can arrive on the very cycle the watchdog would expire, and an invalid double pulse can overlap a genuine refresh. On the transmit half, an input transition can land on the cycle a refresh falls due. The bench provokes these overlaps with random windows in which the pulse lines are cut, and with injected single or double pulses OR-ed onto the lines while the input toggles at random. Each cycle is judged against a bench model, built from the requirements, that gives the expected pulse lines, level and stale flag.

// File: rtl/isolink_pkg.sv
`timescale 1ns/1ps
package isolink_pkg;

  // One cycle on the pulse channel: at most one of the two lines is meant to be high.
  typedef struct packed {
    logic up;
    logic dn;
  } pulse_pair_t;

  // Build the pair of lines for a pulse that carries level lvl.
  function automatic pulse_pair_t encode_pulse(input logic fire, input logic lvl);
    pulse_pair_t p;
    p.up = fire & lvl;
    p.dn = fire & ~lvl;
    return p;
  endfunction

  // A pair carries information only when exactly one line is high.
  function automatic logic pulse_is_valid(input pulse_pair_t p);
    return p.up ^ p.dn;
  endfunction

endpackage

// File: rtl/isolink_tick_timer.sv
`timescale 1ns/1ps
// Saturating interval counter: expired is high once LIMIT-1 cycles have passed since restart.
module isolink_tick_timer #(
  parameter int unsigned LIMIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/isolink_tx.sv
`timescale 1ns/1ps
// Transmit half: edge and refresh encoder.
module isolink_tx
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        din_i,
  output pulse_pair_t pulse_o
);
  logic        armed_q;
  logic        prev_q;
  logic        refresh_due;
  logic        fire;
  pulse_pair_t pulse_q;

  // Send on the first live cycle, on any change, or when the refresh falls due.
  assign fire = ~armed_q | (din_i != prev_q) | refresh_due;

  isolink_tick_timer #(.LIMIT(REFRESH_CYC)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fire),
    .expired (refresh_due)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= din_i;
      pulse_q <= encode_pulse(fire, din_i);
    end
  end

  assign pulse_o = pulse_q;

  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_q.up && pulse_q.dn)); // R2
  AST_TX_NARROW_UP: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q.up |=> !pulse_q.up); // R2
  AST_TX_NARROW_DN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q.dn |=> !pulse_q.dn); // R2
  AST_TX_RISE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $rose(din_i) |=> pulse_q.up); // R1
  AST_TX_FALL_DN: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $fell(din_i) |=> pulse_q.dn); // R1
  AST_TX_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> (pulse_q.up || pulse_q.dn)); // R4

endmodule

// File: rtl/isolink_rx.sv
`timescale 1ns/1ps
// Receive half: bistable decoder with a watchdog.
module isolink_rx
  import isolink_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pulse_pair_t pulse_i,
  output logic        dout_o,
  output logic        stale_o
);
  logic valid;
  logic wd_expired;
  logic lvl_q;
  logic stale_q;

  assign valid = pulse_is_valid(pulse_i);

  isolink_tick_timer #(.LIMIT(TIMEOUT_CYC)) u_watchdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (valid),
    .expired (wd_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b1;
      stale_q <= 1'b1;
    end else if (valid) begin
      lvl_q   <= pulse_i.up;
      stale_q <= 1'b0;
    end else if (wd_expired) begin
      stale_q <= 1'b1;
    end
  end

  assign dout_o  = stale_q | lvl_q;
  assign stale_o = stale_q;

  AST_RX_UP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i.up && !pulse_i.dn |=> dout_o && !stale_o); // R5
  AST_RX_DN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i.dn && !pulse_i.up |=> !dout_o && !stale_o); // R5
  AST_RX_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i.up && pulse_i.dn |=> $stable(lvl_q)); // R6
  AST_RX_STALE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !stale_q && !valid && !wd_expired |=> !stale_q); // R7
  AST_RX_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !stale_o); // R8

endmodule

// File: rtl/isolink_top.sv
`timescale 1ns/1ps
// Pulse-coded level link. Parameter rule: REFRESH_CYC >= 2 and TIMEOUT_CYC > REFRESH_CYC.
module isolink_top
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 400,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic tx_rst_n,
  input  logic rx_rst_n,
  input  logic din_i,
  output logic tx_up_o,
  output logic tx_dn_o,
  input  logic rx_up_i,
  input  logic rx_dn_i,
  output logic dout_o,
  output logic stale_o
);
  pulse_pair_t tx_pair;
  pulse_pair_t rx_pair;

  isolink_tx #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk     (clk),
    .rst_n   (tx_rst_n),
    .din_i   (din_i),
    .pulse_o (tx_pair)
  );

  assign tx_up_o    = tx_pair.up;
  assign tx_dn_o    = tx_pair.dn;
  assign rx_pair.up = rx_up_i;
  assign rx_pair.dn = rx_dn_i;

  isolink_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk     (clk),
    .rst_n   (rx_rst_n),
    .pulse_i (rx_pair),
    .dout_o  (dout_o),
    .stale_o (stale_o)
  );

endmodule

// File: tb/tb_isolink_top.sv
`timescale 1ns/1ps
module tb_isolink_top;
  localparam int R = 12;
  localparam int T = 30;

  logic clk = 1'b0;
  logic tx_rst_n = 1'b0, rx_rst_n = 1'b0, din = 1'b0;
  logic cut = 1'b0, inj_up = 1'b0, inj_dn = 1'b0;
  logic tx_up, tx_dn, dout, stale;
  logic rx_up, rx_dn;

  assign rx_up = (tx_up & ~cut) | inj_up;
  assign rx_dn = (tx_dn & ~cut) | inj_dn;

  isolink_top #(.REFRESH_CYC(R), .TIMEOUT_CYC(T)) dut (
    .clk(clk), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n), .din_i(din),
    .tx_up_o(tx_up), .tx_dn_o(tx_dn), .rx_up_i(rx_up), .rx_dn_i(rx_dn),
    .dout_o(dout), .stale_o(stale)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // Reference model built from the requirements.
  bit m_armed = 0, m_prev = 0, m_up = 0, m_dn = 0, m_lvl = 1, m_stale = 1, m_fire;
  int m_tcnt = 0, m_wcnt = 0;
  bit last_up = 0, last_dn = 0;

  function automatic bit tx_should_fire(bit armed, bit prev, bit d, int cnt);
    return !armed || (d != prev) || (cnt == R - 1);
  endfunction

  function automatic bit exp_dout(bit st, bit lv);
    return st | lv;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!tx_rst_n) begin
      m_armed <= 0; m_prev <= 0; m_up <= 0; m_dn <= 0; m_tcnt <= 0;
    end else begin
      m_fire = tx_should_fire(m_armed, m_prev, din, m_tcnt);
      m_up <= m_fire & din;
      m_dn <= m_fire & ~din;
      m_tcnt <= m_fire ? 0 : ((m_tcnt == R - 1) ? m_tcnt : m_tcnt + 1);
      m_prev <= din;
      m_armed <= 1;
    end
    if (!rx_rst_n) begin
      m_lvl <= 1; m_stale <= 1; m_wcnt <= 0;
    end else if (rx_up ^ rx_dn) begin
      m_lvl <= rx_up; m_stale <= 0; m_wcnt <= 0;
    end else if (m_wcnt == T - 1) begin
      m_stale <= 1;
    end else begin
      m_wcnt <= m_wcnt + 1;
    end
  end

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(tx_up, m_up, "R1 R3 R4 up line");
    check(tx_dn, m_dn, "R1 R3 R4 down line");
    check(tx_up & tx_dn, 1'b0, "R2 exclusive lines");
    check(tx_up & last_up, 1'b0, "R2 narrow up pulse");
    check(tx_dn & last_dn, 1'b0, "R2 narrow down pulse");
    check(dout, exp_dout(m_stale, m_lvl), "R5 dout level");
    check(stale, m_stale, "R7 R8 stale flag");
    last_up = tx_up;
    last_dn = tx_dn;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'd4711));
    repeat (3) tick();
    check(tx_up, 1'b0, "R9 up line in reset");
    check(tx_dn, 1'b0, "R9 down line in reset");
    check(dout, 1'b1, "R9 dout in reset");
    check(stale, 1'b1, "R9 stale in reset");

    rx_rst_n = 1; din = 1;
    tick();
    check(stale, 1'b1, "R9 stale before first pulse");
    tx_rst_n = 1;
    tick();
    check(tx_up, 1'b1, "R4 first pulse after reset");
    gap = 0;
    tick(); gap++;
    check(dout, 1'b1, "R5 high after up pulse");
    check(stale, 1'b0, "R8 stale cleared by pulse");
    while (!tx_up && gap < 4 * R) begin tick(); gap++; end
    check(gap == R, 1'b1, "R3 refresh interval");

    din = 0;
    tick();
    check(tx_dn, 1'b1, "R1 falling edge gives down pulse");
    tick();
    check(dout, 1'b0, "R5 low after down pulse");

    inj_up = 1; inj_dn = 1;
    tick();
    inj_up = 0; inj_dn = 0;
    check(dout, 1'b0, "R6 collision holds level");

    cut = 1;
    for (int i = 0; i < T + 2; i++) begin
      inj_up = i[0]; inj_dn = i[0];
      tick();
    end
    inj_up = 0; inj_dn = 0;
    tick();
    check(stale, 1'b1, "R6 collisions do not restart watchdog");
    check(dout, 1'b1, "R7 output forced high");
    inj_dn = 1;
    tick();
    inj_dn = 0;
    check(stale, 1'b0, "R8 pulse leaves stale state");
    check(dout, 1'b0, "R8 pulse level applied at once");
    cut = 0;

    repeat (5 * T) tick();
    check(stale, 1'b0, "R10 intact link never stale");

    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      if (r < 220) din = ~din;
      if (r >= 300 && r < 312) cut = 1;
      if (cut && r >= 400 && r < 415) cut = 0;
      inj_up = (r >= 500 && r < 510) || (r >= 600 && r < 606);
      inj_dn = (r >= 520 && r < 530) || (r >= 600 && r < 606);
      tx_rst_n = !(r >= 700 && r < 703);
      rx_rst_n = !(r == 800);
      tick();
    end
    cut = 0; inj_up = 0; inj_dn = 0; tx_rst_n = 1; rx_rst_n = 1;
    repeat (4 * T) tick();
    check(stale, 1'b0, "R10 link recovers after random phase");

    done = 1;
    summary();
    $finish;
  end

endmodule